// File: doc/BRIEF.md
# Priority Interrupt Request Arbiter

This block sits on the processor side of a shared peripheral bus. It watches four request lines and compares them against the processor's current 3-bit priority. The four lines stand for urgency levels 4 through 7. When no grant is outstanding, it picks the most urgent request whose level is strictly above that priority. It then raises the one grant line that belongs to that level.

The grant stays up until the device that won acknowledges, or until a programmable number of cycles has passed with no answer. An unanswered grant is taken as a hardware fault. The grant is then withdrawn and a single-cycle trap pulse is raised.

Requests are never stored inside the arbiter. A device that is not served keeps its line asserted and is considered again the next time the arbiter is idle.

Top module: `irq_grant_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, all grant lines, the busy flag, the granted level and the trap output are zero.
- R2: Request bit i stands for level 4+i. When the arbiter is idle and sees that request with level 4+i strictly greater than the processor priority, grant bit i rises after the next clock edge. A request at or below the priority produces no grant.
- R3: When several qualifying requests are present at the sampling edge, the highest level is granted.
- R4: At most one grant line is high at any time. While a grant is high, the busy flag is 1 and the granted-level output equals 4+i for grant bit i.
- R5: While a grant is outstanding, changes to the request lines or the priority do not alter the grant lines.
- R6: An acknowledge seen while a grant is outstanding clears the grant lines and the busy flag after the next clock edge. The granted-level output keeps the serviced level until the next grant.
- R7: A grant left unanswered for TMO_CYCLES clock edges is dropped, and the trap output is high for exactly one cycle immediately after the drop.
- R8: Requests are not latched. A request withdrawn before it qualifies leaves no grant. A request still held after a timeout is granted again.
- R9: An acknowledge while no grant is outstanding has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Request lines, bit i = level 4+i |
| cpu_pri_i | input | 3 | Current processor priority, 0..7 |
| dev_ack_i | input | 1 | Acknowledge from the granted device |
| grant_o | output | 4 | Grant lines, bit i = level 4+i |
| grant_busy_o | output | 1 | A grant is outstanding |
| grant_lvl_o | output | 3 | Level of the current or most recent grant |
| trap_o | output | 1 | One-cycle timeout trap pulse |

## Verification
A wrong qualification or selection shows up as the wrong grant bit, or as a missing or extra grant, one clock after the inputs are presented. The bench sweeps all 128 combinations of priority and request pattern, so every such error is reached. A stuck or mis-sized timer shows as a grant whose length differs from TMO_CYCLES, or as a trap pulse wider than one cycle. Both are visible within TMO_CYCLES+2 clocks. Corrupted held state shows on the next clock as grant lines that move while busy, or as a level that is lost after an acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int IRQ_LVLS  = 4;
  localparam int IRQ_BASE  = 4;
  localparam int IRQ_PRI_W = 3;
endpackage

// File: rtl/irq_level_qualify.sv
module irq_level_qualify #(
  parameter int NUM   = irq_arb_pkg::IRQ_LVLS,
  parameter int BASE  = irq_arb_pkg::IRQ_BASE,
  parameter int PRI_W = irq_arb_pkg::IRQ_PRI_W
) (
  input  logic [NUM-1:0]   req,
  input  logic [PRI_W-1:0] pri,
  output logic [NUM-1:0]   qual
);
  for (genvar g = 0; g < NUM; g++) begin : g_lvl
    localparam logic [PRI_W-1:0] LVL = PRI_W'(BASE + g);
    assign qual[g] = req[g] && (LVL > pri);
  end
endmodule

// File: rtl/irq_top_pick.sv
module irq_top_pick #(
  parameter int NUM   = irq_arb_pkg::IRQ_LVLS,
  parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0]   qual,
  output logic [NUM-1:0]   onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      if (qual[i]) begin
        onehot = '0;
        onehot[i] = 1'b1;
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_grant_timer.sv
module irq_grant_timer #(
  parameter int TMO_CYCLES = 64,
  parameter int CNT_W      = $clog2(TMO_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  output logic expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start)      cnt_q <= '0;
    else if (active)       cnt_q <= cnt_q + 1'b1;
  end

  assign expire = active && (cnt_q == LAST);
endmodule

// File: rtl/irq_grant_arbiter.sv
module irq_grant_arbiter #(
  parameter int NUM        = irq_arb_pkg::IRQ_LVLS,
  parameter int BASE       = irq_arb_pkg::IRQ_BASE,
  parameter int PRI_W      = irq_arb_pkg::IRQ_PRI_W,
  parameter int TMO_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   req_i,
  input  logic [PRI_W-1:0] cpu_pri_i,
  input  logic             dev_ack_i,
  output logic [NUM-1:0]   grant_o,
  output logic             grant_busy_o,
  output logic [PRI_W-1:0] grant_lvl_o,
  output logic             trap_o
);
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

  logic [NUM-1:0]   qual, pick_oh;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any, expire, launch;
  logic [NUM-1:0]   grant_q;
  logic             busy_q, trap_q;
  logic [PRI_W-1:0] lvl_q;

  irq_level_qualify #(.NUM(NUM), .BASE(BASE), .PRI_W(PRI_W)) qual_i (
    .req(req_i), .pri(cpu_pri_i), .qual(qual)
  );

  irq_top_pick #(.NUM(NUM), .IDX_W(IDX_W)) pick_i (
    .qual(qual), .onehot(pick_oh), .idx(pick_idx), .any(pick_any)
  );

  assign launch = !busy_q && pick_any;

  irq_grant_timer #(.TMO_CYCLES(TMO_CYCLES)) tmr_i (
    .clk(clk), .rst(rst), .start(launch),
    .active(busy_q && !dev_ack_i), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      busy_q  <= 1'b0;
      lvl_q   <= '0;
      trap_q  <= 1'b0;
    end else begin
      trap_q <= 1'b0;
      if (launch) begin
        grant_q <= pick_oh;
        busy_q  <= 1'b1;
        lvl_q   <= PRI_W'(BASE) + PRI_W'(pick_idx);
      end else if (busy_q && dev_ack_i) begin
        grant_q <= '0;
        busy_q  <= 1'b0;
      end else if (expire) begin
        grant_q <= '0;
        busy_q  <= 1'b0;
        trap_q  <= 1'b1;
      end
    end
  end

  assign grant_o      = grant_q;
  assign grant_busy_o = busy_q;
  assign grant_lvl_o  = lvl_q;
  assign trap_o       = trap_q;
endmodule

// File: rtl/irq_grant_arbiter_chk.sv
module irq_grant_arbiter_chk #(
  parameter int NUM        = 4,
  parameter int BASE       = 4,
  parameter int PRI_W      = 3,
  parameter int TMO_CYCLES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [NUM-1:0]   req_i,
  input logic [PRI_W-1:0] cpu_pri_i,
  input logic             dev_ack_i,
  input logic [NUM-1:0]   grant_o,
  input logic             grant_busy_o,
  input logic [PRI_W-1:0] grant_lvl_o,
  input logic             trap_o
);
  localparam int RUN_W = $clog2(TMO_CYCLES + 2) + 1;
  logic [RUN_W-1:0] run_q;
  logic [NUM-1:0]   above;

  always_ff @(posedge clk) begin
    if (rst)               run_q <= '0;
    else if (grant_busy_o) run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  assign above = ~((grant_o << 1) - NUM'(1));

  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o) && ((grant_o != '0) == grant_busy_o));

  a_r2_strict: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_busy_o) |-> (int'(grant_lvl_o) > int'($past(cpu_pri_i))));

  a_r3_highest: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_busy_o) |-> (($past(req_i) & above) == '0));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (grant_busy_o && !dev_ack_i) |=> (grant_o == $past(grant_o)) || trap_o);

  a_r6_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (grant_busy_o && dev_ack_i) |=> (grant_o == '0) && !trap_o);

  a_r7_trap_pulse: assert property (@(posedge clk) disable iff (rst)
    trap_o |=> !trap_o);

  a_r7_trap_idle: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !grant_busy_o && $past(grant_busy_o));

  a_r7_window: assert property (@(posedge clk) disable iff (rst)
    grant_busy_o |-> (int'(run_q) < TMO_CYCLES));
endmodule

bind irq_grant_arbiter irq_grant_arbiter_chk #(
  .NUM(NUM), .BASE(BASE), .PRI_W(PRI_W), .TMO_CYCLES(TMO_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .req_i(req_i), .cpu_pri_i(cpu_pri_i),
  .dev_ack_i(dev_ack_i), .grant_o(grant_o), .grant_busy_o(grant_busy_o),
  .grant_lvl_o(grant_lvl_o), .trap_o(trap_o)
);

// File: tb/irq_grant_arbiter_tb.sv
`timescale 1ns/1ps
module irq_grant_arbiter_tb_top;
  localparam int TMO = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req_i = '0;
  logic [2:0] cpu_pri_i = '0;
  logic       dev_ack_i = 1'b0;
  logic [3:0] grant_o;
  logic       grant_busy_o;
  logic [2:0] grant_lvl_o;
  logic       trap_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_grant_arbiter #(.TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .cpu_pri_i(cpu_pri_i),
    .dev_ack_i(dev_ack_i), .grant_o(grant_o), .grant_busy_o(grant_busy_o),
    .grant_lvl_o(grant_lvl_o), .trap_o(trap_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    req_i = 4'hF;
    tick();
    tick();
    // R1: outputs held at zero under reset
    chk(grant_o == 0 && !grant_busy_o && grant_lvl_o == 0 && !trap_o, "R1 reset",
        {grant_o, grant_busy_o, grant_lvl_o, trap_o}, 0);
    req_i = '0;
    rst = 1'b0;
    tick();
    chk(grant_o == 0 && !grant_busy_o && !trap_o, "R1 after reset", grant_o, 0);

    // R9: acknowledge while idle has no effect
    dev_ack_i = 1'b1;
    tick();
    chk(grant_o == 0 && !grant_busy_o && !trap_o && grant_lvl_o == 0, "R9 idle ack",
        {grant_o, grant_busy_o, grant_lvl_o, trap_o}, 0);
    dev_ack_i = 1'b0;

    // R2/R3/R4/R5/R6: full sweep of priority and request pattern
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < 16; r++) begin
        int ei;
        ei = -1;
        for (int i = 0; i < 4; i++) if (r[i] && (4 + i) > p) ei = i;
        cpu_pri_i = 3'(p);
        req_i = 4'(r);
        tick();
        if (ei < 0) begin
          chk(grant_o == 0 && !grant_busy_o, "R2 no qualifying request", grant_o, 0);
        end else begin
          chk(grant_o == 4'(1 << ei), "R3 highest qualified grant", grant_o, 1 << ei);
          chk(grant_busy_o && grant_lvl_o == 3'(4 + ei), "R4 level and busy",
              grant_lvl_o, 4 + ei);
          req_i = 4'hF;
          cpu_pri_i = 3'd0;
          tick();
          chk(grant_o == 4'(1 << ei), "R5 grant held while busy", grant_o, 1 << ei);
          dev_ack_i = 1'b1;
          req_i = '0;
          tick();
          dev_ack_i = 1'b0;
          chk(grant_o == 0 && !grant_busy_o && grant_lvl_o == 3'(4 + ei),
              "R6 ack drops grant keeps level", {grant_o, grant_lvl_o}, 4 + ei);
        end
        req_i = '0;
      end
    end

    // R8: request withdrawn while masked leaves nothing behind
    cpu_pri_i = 3'd7;
    req_i = 4'hF;
    tick();
    tick();
    chk(grant_o == 0, "R2 priority 7 masks all", grant_o, 0);
    req_i = '0;
    cpu_pri_i = 3'd0;
    tick();
    tick();
    chk(grant_o == 0 && !grant_busy_o, "R8 withdrawn request not latched", grant_o, 0);

    // R7: unanswered grant times out with a one-cycle trap
    req_i = 4'b0100;
    tick();
    chk(grant_o == 4'b0100 && !trap_o, "R7 grant raised", grant_o, 4);
    for (int k = 1; k < TMO; k++) begin
      tick();
      chk(grant_o == 4'b0100 && !trap_o, "R7 grant held before timeout", grant_o, 4);
    end
    tick();
    chk(grant_o == 0 && !grant_busy_o && trap_o, "R7 timeout drop and trap",
        {grant_o, trap_o}, 1);
    tick();
    chk(!trap_o, "R7 trap single cycle", trap_o, 0);
    chk(grant_o == 4'b0100 && grant_lvl_o == 3'd6, "R8 held request regranted",
        grant_o, 4);
    dev_ack_i = 1'b1;
    req_i = '0;
    tick();
    dev_ack_i = 1'b0;
    chk(grant_o == 0 && !trap_o, "R6 ack after regrant", grant_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule